// File: doc/BRIEF.md
# Registered Driver with Transparent Bypass

This block carries an 18-bit word from its inputs to its outputs through one storage element per bit. The element works in two ways, chosen by an active-low latch enable. With the enable low, it is a transparent latch and the output follows the input. With the enable high, it is an edge-triggered register that loads the input word only on a rising clock edge and otherwise holds it.

A separate active-low output enable sits in front of the output pins. With the output enable high, the pins are released to high impedance. With it low, the pins present the stored or passed word. The output gate never touches the storage, so data can still be captured or passed while the pins float.

Alongside the three-state pins, the block brings out the stored value and a drive-enable flag. A surrounding design or a bench can observe both without resolving a three-state net.

Top module: `rgd_driver`

## Requirements
- R1: While `le_n_i` is 0, every bit of `q_o` equals the same bit of `a_i`, whether `clk_i` is low, high or toggling.
- R2: While `le_n_i` is 1 and no rising edge of `clk_i` occurs, `q_o` keeps its value: changes on `a_i` and falling clock edges have no effect.
- R3: While `le_n_i` is 1, a rising edge of `clk_i` loads the current `a_i` word into storage, and it appears on `q_o` right after that edge.
- R4: If `le_n_i` rises while `clk_i` is already high, `q_o` holds the word that was passing just before, and nothing is loaded until the next rising clock edge.
- R5: When `le_n_i` rises after a transparent period, `q_o` keeps the last transparent word and does not return to any word captured by an earlier clock edge.
- R6: With `oe_n_i` at 1, `out_en_o` is 0 and `y_io` is high impedance. With `oe_n_i` at 0, `out_en_o` is 1 and `y_io` equals `q_o`.
- R7: Changing `oe_n_i` never changes `q_o`. Capture on a clock edge and transparent passing both keep working while `oe_n_i` is 1.
- R8: All 18 bits are stored independently under the shared controls. A word with a single 1 (or a single 0) at any position reaches `q_o` unaltered in both transparent and clocked operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 18 | Data word to store or pass |
| le_n_i | input | 1 | Latch enable, active low: 0 = transparent, 1 = clocked |
| clk_i | input | 1 | Capture clock; the rising edge loads data while `le_n_i` is 1 |
| oe_n_i | input | 1 | Output enable, active low: 1 releases `y_io` to high impedance |
| y_io | inout | 18 | Three-state data outputs |
| out_en_o | output | 1 | 1 while `y_io` is being driven |
| q_o | output | 18 | Stored or transparent word, independent of the output gate |

## Verification
The hardest case to reach is the latch enable rising while the clock is already high. The element then has to keep the passed word and ignore the clock level it is sitting on. The bench reaches this case by raising the latch enable just after a rising clock edge, while the latch is still transparent. It then changes the input during the rest of that high phase and through the falling edge. A second sequence first captures one word on an edge and then opens the latch over a full clock period to pass a different word. When the latch closes, this shows that no earlier clocked word comes back. Both sequences are repeated with the outputs floating.

// File: rtl/rgd_pkg.sv
// Package: shared constants for the registered driver.
// Assumes: the default width applies when no override is given.
package rgd_pkg;
    parameter int unsigned RGD_WIDTH = 18;
endpackage

// File: rtl/rgd_mode_track.sv
// Module: rgd_mode_track
// Records whether the storage has seen a rising clock edge since the
// latch enable last went high. This decides whether the clocked copy or
// the transparent copy is the current held value.
// Assumes: le_n_i low means transparent; the flag clears at once when
// le_n_i falls.
module rgd_mode_track (
    input  logic clk_i,
    input  logic le_n_i,
    output logic clocked_o
);
    logic clocked_q;

    // Set on an edge taken in clocked mode; clear as soon as transparency starts.
    always_ff @(posedge clk_i or negedge le_n_i) begin
        if (!le_n_i) begin
            clocked_q <= 1'b0;
        end else begin
            clocked_q <= 1'b1;
        end
    end

    assign clocked_o = clocked_q;
endmodule

// File: rtl/rgd_store_cell.sv
// Module: rgd_store_cell
// One bit of storage that acts as a transparent latch or as an
// edge-triggered register. A latch copy follows the data while le_n_i is
// low. A register copy loads on a rising clock edge while le_n_i is high.
// The mode flag picks the newer of the two.
// Assumes: use_clocked_i comes from rgd_mode_track on the same controls.
module rgd_store_cell (
    input  logic clk_i,
    input  logic le_n_i,
    input  logic use_clocked_i,
    input  logic d_i,
    output logic q_o
);
    logic lat_q;
    logic reg_q;

    // Latch copy: follows data while transparent, freezes when le_n_i rises.
    always_latch begin
        if (!le_n_i) begin
            lat_q = d_i;
        end
    end

    // Register copy: loads on the rising edge only in clocked mode.
    always_ff @(posedge clk_i) begin
        if (le_n_i) begin
            reg_q <= d_i;
        end
    end

    // Output select: live data, last edge capture, or last passed value.
    always_comb begin
        if (!le_n_i) begin
            q_o = d_i;
        end else if (use_clocked_i) begin
            q_o = reg_q;
        end else begin
            q_o = lat_q;
        end
    end
endmodule

// File: rtl/rgd_out_gate.sv
// Module: rgd_out_gate
// Three-state output gate: drives the stored word onto the pins while
// oe_n_i is low and releases them otherwise. It also reports the drive
// state on a plain output.
// Assumes: it never feeds back into storage.
module rgd_out_gate #(
    parameter int unsigned W = 18
) (
    input  logic         oe_n_i,
    input  logic [W-1:0] q_i,
    inout  wire  [W-1:0] y_io,
    output logic         en_o
);
    // Drive enable derived from the active-low control.
    assign en_o = ~oe_n_i;

    // Pin drive: stored word or high impedance.
    assign y_io = en_o ? q_i : {W{1'bz}};
endmodule

// File: rtl/rgd_driver.sv
// Module: rgd_driver (top)
// Registered driver with a transparent bypass and a three-state output.
// Each bit has one storage cell that shares the latch enable, the clock
// and a common mode flag. The output gate sits behind the storage.
// Assumes: there is no reset, so storage is undefined until it is loaded
// by transparency or by a clock edge.
module rgd_driver #(
    parameter int unsigned W = rgd_pkg::RGD_WIDTH
) (
    input  logic [W-1:0] a_i,
    input  logic         le_n_i,
    input  logic         clk_i,
    input  logic         oe_n_i,
    inout  wire  [W-1:0] y_io,
    output logic         out_en_o,
    output logic [W-1:0] q_o
);
    logic         use_clocked;
    logic [W-1:0] store_q;

    rgd_mode_track mode_i (
        .clk_i     (clk_i),
        .le_n_i    (le_n_i),
        .clocked_o (use_clocked)
    );

    // One storage cell per data bit.
    for (genvar b = 0; b < W; b++) begin : g_bit
        rgd_store_cell cell_i (
            .clk_i         (clk_i),
            .le_n_i        (le_n_i),
            .use_clocked_i (use_clocked),
            .d_i           (a_i[b]),
            .q_o           (store_q[b])
        );
    end

    rgd_out_gate #(.W(W)) gate_i (
        .oe_n_i (oe_n_i),
        .q_i    (store_q),
        .y_io   (y_io),
        .en_o   (out_en_o)
    );

    assign q_o = store_q;
endmodule

// File: rtl/rgd_driver_chk.sv
// Module: rgd_driver_chk
// Checker for rgd_driver, attached to it by the bind below.
// Assumes: the latch enable does not go low and back high again between
// two rising clock edges.
module rgd_driver_chk #(
    parameter int unsigned W = 18
) (
    input logic [W-1:0] a_i,
    input logic         le_n_i,
    input logic         clk_i,
    input logic         oe_n_i,
    input logic [W-1:0] y_io,
    input logic         out_en_o,
    input logic [W-1:0] q_o
);
    // R1: a transparent latch shows the input at the edge.
    a_r1_transparent: assert property (@(posedge clk_i)
        !le_n_i |-> (q_o == a_i));

    // R3: a word loaded in clocked mode is still present one edge later.
    a_r3_capture: assert property (@(posedge clk_i)
        le_n_i |=> (!le_n_i || (q_o == $past(a_i))));

    // R6: floating pins go with the deasserted drive flag.
    a_r6_release: assert property (@(posedge clk_i)
        oe_n_i |-> !out_en_o);

    // R6: driven pins carry the stored word.
    a_r6_drive: assert property (@(posedge clk_i)
        !oe_n_i |-> (out_en_o && (y_io == q_o)));

    // R7: with the latch closed, a change of output enable alone leaves storage as is.
    a_r7_oe_isolated: assert property (@(posedge clk_i)
        (le_n_i && $past(le_n_i) && $stable(a_i) && !$stable(oe_n_i))
        |=> (!le_n_i || $stable(q_o)));
endmodule

bind rgd_driver rgd_driver_chk #(.W(W)) chk_i (
    .a_i      (a_i),
    .le_n_i   (le_n_i),
    .clk_i    (clk_i),
    .oe_n_i   (oe_n_i),
    .y_io     (y_io),
    .out_en_o (out_en_o),
    .q_o      (q_o)
);

// File: tb/rgd_driver_tb_top.sv
`timescale 1ns/1ps
module rgd_driver_tb_top;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic [W-1:0] a = '0;
    logic         le_n = 1'b0;
    logic         oe_n = 1'b0;
    wire  [W-1:0] y_w;
    logic         out_en;
    logic [W-1:0] q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    rgd_driver #(.W(W)) dut_i (
        .a_i      (a),
        .le_n_i   (le_n),
        .clk_i    (clk),
        .oe_n_i   (oe_n),
        .y_io     (y_w),
        .out_en_o (out_en),
        .q_o      (q)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    // Behavioural reference: pass while transparent, load on a rising edge otherwise.
    logic [W-1:0] mdl = '0;
    logic         prev_clk = 1'b0;
    always @(a or le_n or clk) begin
        if (!le_n) mdl = a;
        else if (clk && !prev_clk) mdl = a;
        prev_clk = clk;
    end

    task automatic expect_q(input string tag, input logic [W-1:0] exp);
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s q actual=%h expected=%h", tag, q, exp);
        end
    endtask

    task automatic check_all(input string tag);
        expect_q(tag, mdl);
        checks++;
        if (out_en !== !oe_n) begin
            errors++;
            $display("FAIL R6 out_en actual=%b expected=%b", out_en, !oe_n);
        end
        if (!oe_n) begin
            checks++;
            if (y_w !== mdl) begin
                errors++;
                $display("FAIL R6 y actual=%h expected=%h", y_w, mdl);
            end
        end
    endtask

    task automatic in_low();  @(negedge clk); #0.5; endtask
    task automatic in_high(); @(posedge clk); #0.5; endtask
    task automatic settle();  #0.3; endtask

    // Compare against the reference on every clock.
    always @(posedge clk) begin
        #1;
        if (!done) check_all(le_n ? "R3" : "R1");
    end

    initial begin
        #40000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] kept;
        repeat (2) in_low();
        // Load a known value transparently (no reset exists).
        a = 18'h2AAAA; settle(); expect_q("R1", 18'h2AAAA); check_all("R1");
        in_high(); a = 18'h15555; settle(); expect_q("R1", 18'h15555);

        // R4: latch enable rises while the clock is already high.
        le_n = 1'b1; settle(); expect_q("R4", 18'h15555);
        a = 18'h3FFFF; settle(); expect_q("R4", 18'h15555);
        in_low(); a = 18'h00F0F; settle(); expect_q("R2", 18'h15555);
        in_high(); expect_q("R3", 18'h00F0F);
        a = 18'h11111; settle(); expect_q("R2", 18'h00F0F);
        in_low(); a = 18'h22222; settle(); expect_q("R2", 18'h00F0F);

        // R5: capture one word, open the latch across an edge, then close it.
        a = 18'h12345; in_high(); expect_q("R3", 18'h12345);
        in_low(); le_n = 1'b0; a = 18'h0ABCD; settle(); expect_q("R1", 18'h0ABCD);
        in_high(); a = 18'h1F00F; settle(); expect_q("R1", 18'h1F00F);
        in_low(); le_n = 1'b1; settle(); expect_q("R5", 18'h1F00F);
        a = 18'h05A5A; settle(); expect_q("R5", 18'h1F00F);
        in_high(); expect_q("R3", 18'h05A5A);

        // R7: outputs floating; storage must still work and stay put.
        in_low(); oe_n = 1'b1; settle(); check_all("R6"); expect_q("R7", 18'h05A5A);
        a = 18'h3C3C3; in_high(); expect_q("R7", 18'h3C3C3); check_all("R7");
        in_low(); le_n = 1'b0; a = 18'h0F0F0; settle(); expect_q("R7", 18'h0F0F0);
        in_high(); in_low(); le_n = 1'b1; a = 18'h00001; settle();
        kept = q;
        oe_n = 1'b0; settle(); expect_q("R7", kept); check_all("R6");
        oe_n = 1'b1; settle(); expect_q("R7", kept);
        oe_n = 1'b0; settle(); check_all("R6");

        // R8: walking one through the transparent path.
        in_low(); le_n = 1'b0;
        for (int i = 0; i < W; i++) begin
            a = 18'(1) << i; settle(); expect_q("R8", 18'(1) << i);
        end
        in_high(); in_low(); le_n = 1'b1;
        // R8: walking zero through the clocked path.
        for (int i = 0; i < W; i++) begin
            a = ~(18'(1) << i);
            in_high(); expect_q("R8", ~(18'(1) << i)); check_all("R8");
            in_low();
        end
        done = 1'b1;
        #1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule